// File: doc/BRIEF.md
# SD Host Data FIFO Byte Packer

This block is the data path of an SD host controller, sitting between the 32-bit host data register and the byte-wide card data lines. A 16-word circular FIFO sits in the middle. When the command selects a read, bytes arriving from the card are packed into words, least significant lane first, and pushed into the FIFO for the host to pop. When the command selects a write, words the host has pushed are popped and sent to the card one byte at a time, lowest byte first.

The number of bytes to move is set by a block size and a block count. Writing the block count loads a remaining-byte counter with their product. The engine runs on every clock while that counter is nonzero and its direction bit is set. At each word boundary it raises sticky status bits: a data flag, a data interrupt, and, for writes, a block interrupt at each block end. A debug word reports the FIFO fill level and a mode nibble. The mode nibble switches to "data mode" when the count runs out.

The card side uses valid/ready handshakes. A byte moves on a clock edge where both valid and ready are high. On the receive side, `card_rx_ready` applies back-pressure: it is high only while a read is active, bytes remain and the FIFO has room. The card may hold `card_rx_valid` for as long as it likes. On the send side, `card_tx_valid` stays high with `card_tx_data` unchanged until the card raises `card_tx_ready`. At most one byte moves per cycle. The host register strobes are plain single-cycle pulses with no handshake.

Top module: `sdh_data_packer`

## Requirements
- R1: The FIFO holds 16 words in a ring. A host word push while the level is 16 is dropped with no effect on the level or contents. A host pop while empty returns 0 on `host_rd_data` and leaves the level at 0.
- R2: A `bcnt_wr` pulse sets the remaining byte count to `bcnt_wdata` × the stored block size. While the count is zero, no byte moves in either direction.
- R3: `card_rx_ready` is high only when `dir_read` is 1, the remaining count is nonzero and the level is below 16. Bytes are packed little-endian: the first byte of a word lands in bits 7:0, the next in 15:8, and so on.
- R4: When the count reaches zero partway through a word, that word is still pushed. Its unfilled upper lanes read as zero.
- R5: While `dir_write` is 1 and `dir_read` is 0, popped words are sent lowest byte first. `card_tx_valid` is asserted only while bytes remain and a word is partly unsent. It stays high with stable data until `card_tx_ready`.
- R6: Each word the engine pushes or pops sets status bit 0. If `cfg_data_irq` was latched as 1, it also sets status bit 8. `irq_o` is high when status bit 8 or bit 9 is set.
- R7: In the write direction, status bit 9 is set when a sent byte completes a block, meaning the remaining count becomes a multiple of a nonzero block size. This happens only if `cfg_block_irq` was latched as 1.
- R8: Status bits are sticky. A `sts_clr_wr` pulse clears the bits set in `sts_clr_mask`. A set arriving in the same cycle wins over the clear.
- R9: When the remaining count goes from 1 to 0, debug bits 3:0 become 1.
- R10: Debug bits 8:4 always show the current FIFO level.
- R11: The debug word resets to 0x0000C60F. A `dbg_wr` stores `dbg_wdata`, except that a low nibble of 0xF is stored as 0. Bits 8:4 always read as the level.
- R12: `host_rd_data` shows the oldest FIFO word. A `host_rd_req` pulse removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Push `host_wr_data` into the FIFO |
| host_wr_data | input | 32 | Word written by the host |
| host_rd_req | input | 1 | Pop the head word |
| host_rd_data | output | 32 | Head word, 0 when empty |
| dir_read | input | 1 | Command selects card-to-host transfer |
| dir_write | input | 1 | Command selects host-to-card transfer |
| cfg_wr | input | 1 | Latch the two interrupt enables |
| cfg_data_irq | input | 1 | Data interrupt enable value |
| cfg_block_irq | input | 1 | Block interrupt enable value |
| bsize_wr | input | 1 | Store the block size |
| bsize_wdata | input | 10 | Block size in bytes |
| bcnt_wr | input | 1 | Load the remaining count from the block count |
| bcnt_wdata | input | 9 | Block count |
| sts_clr_wr | input | 1 | Clear status bits |
| sts_clr_mask | input | 10 | Bits to clear |
| status_o | output | 10 | Sticky status: bit 0 data, bit 8 data irq, bit 9 block irq |
| irq_o | output | 1 | Interrupt level |
| dbg_wr | input | 1 | Write the debug word |
| dbg_wdata | input | 32 | Debug write value |
| dbg_o | output | 32 | Debug word with level in bits 8:4 |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Byte for the card available |
| card_tx_data | output | 8 | Byte for the card |
| card_tx_ready | input | 1 | Card accepts the byte |

## Verification
The hardest state to reach from the ports is a full FIFO with a read still pending. Here `card_rx_ready` must drop while bytes remain, and a host push must vanish without trace. The bench loads a 68-byte read and streams 64 card bytes with no host pops. It then checks that back-pressure holds and a host push leaves the level at 16. One pop must reopen the card side for the last word. A second awkward case is a write-direction byte held under back-pressure while the next word waits. The bench gets there by keeping `card_tx_ready` low after two host pushes, then checking the held byte and the level of one.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int STS_W     = 10;
  localparam int STS_DATA  = 0;
  localparam int STS_SDIO  = 8;
  localparam int STS_BLOCK = 9;

  localparam logic [31:0] DBG_RESET  = 32'h0000_C60F;
  localparam logic [3:0]  MODE_DATA  = 4'h1;
  localparam logic [3:0]  MODE_PWRDN = 4'hF;
  localparam int          DBG_LVL_LSB = 4;
  localparam int          DBG_LVL_W   = 5;
  localparam int          DBG_LVL_MSB = DBG_LVL_LSB + DBG_LVL_W - 1;
endpackage

// File: rtl/sdh_word_fifo.sv
module sdh_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic            full,
  output logic            empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_pop, do_push;
  logic [AW-1:0] wr_idx;

  assign full   = (level_q == LW'(DEPTH));
  assign empty  = (level_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign wr_idx  = rd_ptr_q + level_q[AW-1:0];
  assign rdata   = empty ? '0 : mem[rd_ptr_q];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= wdata;
  end
endmodule

// File: rtl/sdh_rx_packer.sv
module sdh_rx_packer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         allow,
  input  logic         last,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  output logic         in_ready,
  output logic         take,
  output logic         push,
  output logic [W-1:0] push_word
);
  localparam int LANES = W / 8;
  localparam int LW    = $clog2(LANES);

  logic [W-1:0]  acc_q;
  logic [LW-1:0] lane_q;
  logic [W-1:0]  merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = (lane_q == LW'(i)) ? in_data : acc_q[8*i +: 8];
  end

  assign in_ready  = allow;
  assign take      = allow && in_valid;
  assign push      = take && ((lane_q == LW'(LANES - 1)) || last);
  assign push_word = merged;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (take) begin
      if (push) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else begin
        acc_q  <= merged;
        lane_q <= lane_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdh_tx_unpacker.sv
module sdh_tx_unpacker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         allow,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_word,
  input  logic         hold_off,
  input  logic         out_ready,
  output logic         pop,
  output logic         out_valid,
  output logic [7:0]   out_data,
  output logic         sent
);
  localparam int LANES = W / 8;
  localparam int CW    = $clog2(LANES) + 1;

  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;

  assign pop       = allow && (left_q == '0) && !fifo_empty && !hold_off;
  assign out_valid = allow && (left_q != '0);
  assign out_data  = sh_q[7:0];
  assign sent      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (pop) begin
      sh_q   <= fifo_word;
      left_q <= CW'(LANES);
    end else if (sent) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdh_data_packer.sv
module sdh_data_packer
  import sdh_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BSZ_W  = 10,
  parameter int BCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [31:0]       host_wr_data,
  input  logic              host_rd_req,
  output logic [31:0]       host_rd_data,
  input  logic              dir_read,
  input  logic              dir_write,
  input  logic              cfg_wr,
  input  logic              cfg_data_irq,
  input  logic              cfg_block_irq,
  input  logic              bsize_wr,
  input  logic [BSZ_W-1:0]  bsize_wdata,
  input  logic              bcnt_wr,
  input  logic [BCNT_W-1:0] bcnt_wdata,
  input  logic              sts_clr_wr,
  input  logic [STS_W-1:0]  sts_clr_mask,
  output logic [STS_W-1:0]  status_o,
  output logic              irq_o,
  input  logic              dbg_wr,
  input  logic [31:0]       dbg_wdata,
  output logic [31:0]       dbg_o,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready
);
  localparam int WORD_W = 32;
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int REM_W  = BSZ_W + BCNT_W;

  logic [REM_W-1:0] rem_q;
  logic [BSZ_W-1:0] bsize_q, blk_left_q;
  logic             dirq_q, birq_q;
  logic [STS_W-1:0] status_q, status_d;
  logic [31:0]      dbg_q;

  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_wdata, f_rdata;
  logic [LVL_W-1:0]  f_level;

  logic              rx_allow, rx_take, rx_push;
  logic [WORD_W-1:0] rx_word;
  logic              tx_allow, tx_pop, tx_sent;
  logic              rem_nz, rem_last, byte_moved, block_hit, engine_word;

  assign rem_nz     = (rem_q != '0);
  assign rem_last   = (rem_q == REM_W'(1));
  assign rx_allow   = dir_read && rem_nz && !f_full;
  assign tx_allow   = dir_write && !dir_read && rem_nz;
  assign byte_moved = rx_take || tx_sent;
  assign block_hit  = tx_sent && (bsize_q != '0) && (blk_left_q == BSZ_W'(1));
  assign engine_word = rx_push || tx_pop;

  assign f_push  = rx_push || host_wr;
  assign f_wdata = rx_push ? rx_word : host_wr_data;
  assign f_pop   = host_rd_req || tx_pop;

  sdh_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .rdata(f_rdata),
    .level(f_level), .full(f_full), .empty(f_empty)
  );

  sdh_rx_packer #(.W(WORD_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .clr(bcnt_wr),
    .allow(rx_allow), .last(rem_last),
    .in_valid(card_rx_valid), .in_data(card_rx_data),
    .in_ready(card_rx_ready), .take(rx_take),
    .push(rx_push), .push_word(rx_word)
  );

  sdh_tx_unpacker #(.W(WORD_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .clr(bcnt_wr),
    .allow(tx_allow), .fifo_empty(f_empty), .fifo_word(f_rdata),
    .hold_off(host_rd_req), .out_ready(card_tx_ready),
    .pop(tx_pop), .out_valid(card_tx_valid), .out_data(card_tx_data),
    .sent(tx_sent)
  );

  assign host_rd_data = f_rdata;

  // Byte counter and per-block countdown
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q      <= '0;
      bsize_q    <= '0;
      blk_left_q <= '0;
    end else begin
      if (bsize_wr) bsize_q <= bsize_wdata;
      if (bcnt_wr) begin
        rem_q      <= REM_W'(bcnt_wdata) * REM_W'(bsize_q);
        blk_left_q <= bsize_q;
      end else begin
        if (byte_moved) rem_q <= rem_q - 1'b1;
        if (tx_sent)
          blk_left_q <= (blk_left_q == BSZ_W'(1)) ? bsize_q : blk_left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirq_q <= 1'b0;
      birq_q <= 1'b0;
    end else if (cfg_wr) begin
      dirq_q <= cfg_data_irq;
      birq_q <= cfg_block_irq;
    end
  end

  always_comb begin
    status_d = status_q;
    if (sts_clr_wr) status_d = status_d & ~sts_clr_mask;
    if (engine_word) begin
      status_d[STS_DATA] = 1'b1;
      if (dirq_q) status_d[STS_SDIO] = 1'b1;
    end
    if (block_hit && birq_q) status_d[STS_BLOCK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_o    = status_q[STS_SDIO] | status_q[STS_BLOCK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q <= DBG_RESET;
    end else begin
      if (dbg_wr)
        dbg_q <= {dbg_wdata[31:4],
                  (dbg_wdata[3:0] == MODE_PWRDN) ? 4'h0 : dbg_wdata[3:0]};
      if (byte_moved && rem_last)
        dbg_q[3:0] <= MODE_DATA;
    end
  end

  assign dbg_o = {dbg_q[31:DBG_LVL_MSB+1], DBG_LVL_W'(f_level), dbg_q[DBG_LVL_LSB-1:0]};
endmodule

// File: rtl/sdh_data_packer_chk.sv
module sdh_data_packer_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dir_read,
  input logic        dir_write,
  input logic        bcnt_wr,
  input logic        sts_clr_wr,
  input logic [9:0]  status_o,
  input logic [31:0] dbg_o,
  input logic        card_rx_ready,
  input logic        card_tx_valid,
  input logic        card_tx_ready,
  input logic [7:0]  card_tx_data
);
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dbg_o[8:4]) <= DEPTH);

  assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> (dir_read && (32'(dbg_o[8:4]) != DEPTH)));

  assert_tx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> (dir_write && !dir_read));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready && !bcnt_wr)
      |=> (!dir_write || dir_read || (card_tx_valid && $stable(card_tx_data))));

  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status_o[0]) || $fell(status_o[8]) || $fell(status_o[9])) |-> $past(sts_clr_wr));
endmodule

bind sdh_data_packer sdh_data_packer_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .dir_read(dir_read), .dir_write(dir_write),
  .bcnt_wr(bcnt_wr), .sts_clr_wr(sts_clr_wr), .status_o(status_o),
  .dbg_o(dbg_o), .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
  .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data)
);

// File: tb/test_sdh_data_packer.sv
module test_sdh_data_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd_req = 0;
  logic [31:0] host_wr_data = 0;
  logic [31:0] host_rd_data;
  logic        dir_read = 0, dir_write = 0;
  logic        cfg_wr = 0, cfg_data_irq = 0, cfg_block_irq = 0;
  logic        bsize_wr = 0, bcnt_wr = 0;
  logic [9:0]  bsize_wdata = 0;
  logic [8:0]  bcnt_wdata = 0;
  logic        sts_clr_wr = 0;
  logic [9:0]  sts_clr_mask = 0;
  logic [9:0]  status_o;
  logic        irq_o;
  logic        dbg_wr = 0;
  logic [31:0] dbg_wdata = 0;
  logic [31:0] dbg_o;
  logic        card_rx_valid = 0;
  logic [7:0]  card_rx_data = 0;
  logic        card_rx_ready;
  logic        card_tx_valid;
  logic [7:0]  card_tx_data;
  logic        card_tx_ready = 0;

  int checks = 0, failures = 0;
  bit done = 0;
  int tx_seen = 0;
  logic [7:0]  exp_tx[$];
  logic [31:0] exp_rd[$];

  always #10 clk = ~clk;

  sdh_data_packer i_sdh_data_packer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: card-side bytes compared against the scoreboard queue (R5)
  always @(negedge clk) begin
    #2;
    if (rst_n && card_tx_valid && card_tx_ready) begin
      tx_seen++;
      if (exp_tx.size() == 0) chk("R5 unexpected tx byte", {24'h0, card_tx_data}, 32'hFFFF_FFFF);
      else chk("R5 tx byte order", {24'h0, card_tx_data}, {24'h0, exp_tx.pop_front()});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_push(input logic [31:0] w, input bit expect_tx);
    @(negedge clk); host_wr = 1; host_wr_data = w;
    if (expect_tx) for (int i = 0; i < 4; i++) exp_tx.push_back(w[8*i +: 8]);
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_pop_check(input string req);
    logic [31:0] e;
    @(negedge clk); host_rd_req = 1; #1;
    e = (exp_rd.size() != 0) ? exp_rd.pop_front() : 32'h0;
    chk(req, host_rd_data, e);
    @(negedge clk); host_rd_req = 0;
  endtask

  task automatic set_cfg(input bit d, input bit b);
    @(negedge clk); cfg_wr = 1; cfg_data_irq = d; cfg_block_irq = b;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic load_count(input int bsz, input int bcnt);
    @(negedge clk); bsize_wr = 1; bsize_wdata = 10'(bsz);
    @(negedge clk); bsize_wr = 0; bcnt_wr = 1; bcnt_wdata = 9'(bcnt);
    @(negedge clk); bcnt_wr = 0;
  endtask

  task automatic clr_status(input logic [9:0] m);
    @(negedge clk); sts_clr_wr = 1; sts_clr_mask = m;
    @(negedge clk); sts_clr_wr = 0;
  endtask

  task automatic wr_dbg(input logic [31:0] v);
    @(negedge clk); dbg_wr = 1; dbg_wdata = v;
    @(negedge clk); dbg_wr = 0;
  endtask

  task automatic feed_rx(input logic [7:0] b);
    int guard;
    @(negedge clk); card_rx_valid = 1; card_rx_data = b; #1;
    guard = 0;
    while (!card_rx_ready && guard < 100) begin
      @(negedge clk); #1; guard++;
    end
    if (guard >= 100) chk("R3 rx stalled", 0, 1);
    @(posedge clk);
  endtask

  task automatic rx_idle();
    @(negedge clk); card_rx_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; #1;
    // Reset state
    chk("R11 debug reset", dbg_o, 32'h0000_C60F);
    chk("R6 status reset", {22'h0, status_o}, 0);
    chk("R6 irq reset", {31'h0, irq_o}, 0);
    chk("R1 empty head reads zero", host_rd_data, 0);

    // Debug write: power-down nibble stored as zero, level field from FIFO
    wr_dbg(32'h1234_567F); #1;
    chk("R11 debug write nibble F", dbg_o, 32'h1234_5600);
    wr_dbg(32'h0000_C600);

    // Read direction, 6 bytes: one full word plus a partial word
    dir_read = 1;
    set_cfg(1, 0);
    load_count(6, 1);
    for (int i = 0; i < 6; i++) feed_rx(8'h11 + 8'(i));
    rx_idle(); cyc(1); #1;
    chk("R2 rx ready low when count done", {31'h0, card_rx_ready}, 0);
    chk("R10 level after read", {27'h0, dbg_o[8:4]}, 2);
    chk("R9 data mode nibble", {28'h0, dbg_o[3:0]}, 1);
    chk("R6 status data+sdio", {22'h0, status_o}, 32'h101);
    chk("R6 irq raised", {31'h0, irq_o}, 1);
    exp_rd.push_back(32'h1413_1211);
    exp_rd.push_back(32'h0000_1615);
    host_pop_check("R3 little-endian word");
    host_pop_check("R4 partial word padded");
    host_pop_check("R1 pop empty returns zero");
    #1 chk("R1 level stays zero", {27'h0, dbg_o[8:4]}, 0);
    clr_status(10'h3FF); #1;
    chk("R8 status cleared", {22'h0, status_o}, 0);
    chk("R8 irq cleared", {31'h0, irq_o}, 0);

    // Fill the FIFO to capacity with a read still pending
    set_cfg(0, 0);
    load_count(4, 17);
    for (int i = 0; i < 64; i++) feed_rx(8'(i));
    rx_idle(); cyc(1); #1;
    chk("R3 back-pressure when full", {31'h0, card_rx_ready}, 0);
    chk("R10 level full", {27'h0, dbg_o[8:4]}, 16);
    host_push(32'hFFFF_FFFF, 0); #1;
    chk("R1 push when full dropped", {27'h0, dbg_o[8:4]}, 16);
    for (int i = 0; i < 16; i++)
      exp_rd.push_back({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    exp_rd.push_back(32'h4342_4140);
    host_pop_check("R12 head word after full");
    #1 chk("R3 ready after room freed", {31'h0, card_rx_ready}, 1);
    for (int i = 64; i < 68; i++) feed_rx(8'(i));
    rx_idle(); cyc(1);
    for (int i = 0; i < 16; i++) host_pop_check("R12 drain order");
    #1;
    chk("R6 data flag without sdio", {22'h0, status_o}, 32'h001);
    chk("R6 no irq when disabled", {31'h0, irq_o}, 0);
    dir_read = 0;
    clr_status(10'h3FF);

    // Write direction with back-pressure and block interrupt
    dir_write = 1;
    set_cfg(1, 1);
    wr_dbg(32'h0000_C600);
    load_count(4, 2);
    host_push(32'hA3A2_A1A0, 1);
    host_push(32'hB3B2_B1B0, 1);
    cyc(3); #1;
    chk("R5 tx valid held under stall", {31'h0, card_tx_valid}, 1);
    chk("R5 tx first byte lowest", {24'h0, card_tx_data}, 32'hA0);
    chk("R10 level after one pop", {27'h0, dbg_o[8:4]}, 1);
    @(negedge clk); card_tx_ready = 1;
    cyc(14); #1;
    chk("R5 all bytes sent", tx_seen, 8);
    chk("R7 block irq set", {31'h0, status_o[9]}, 1);
    chk("R6 status after write", {22'h0, status_o}, 32'h301);
    chk("R9 nibble after write", {28'h0, dbg_o[3:0]}, 1);
    chk("R2 tx idle after count", {31'h0, card_tx_valid}, 0);

    // Block interrupt disabled
    clr_status(10'h3FF);
    set_cfg(1, 0);
    load_count(4, 1);
    host_push(32'hC3C2_C1C0, 1);
    cyc(10); #1;
    chk("R7 no block irq when disabled", {22'h0, status_o}, 32'h101);
    chk("R5 bytes sent", tx_seen, 12);

    // Zero block count: nothing moves
    clr_status(10'h3FF);
    load_count(4, 0);
    host_push(32'hDEAD_BEEF, 0);
    cyc(6); #1;
    chk("R2 zero count no tx", {31'h0, card_tx_valid}, 0);
    chk("R2 word kept", {27'h0, dbg_o[8:4]}, 1);
    dir_write = 0;
    exp_rd.push_back(32'hDEAD_BEEF);
    host_pop_check("R12 word returned");
    chk("R5 no stray bytes", exp_tx.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule